// File: doc/BRIEF.md
# Execution Trace and Event Logger

This debug block sits next to a small stack-based processor core and watches its execution. On every cycle the core marks as executed, the block forms a trace packet from the program counter, the top-of-stack value and the opcode, and writes it into a circular trace store. When the store is full, the newest packet replaces the oldest one and a sticky wrap flag is raised. Packets are compressed: the program counter field is zeroed and a presence flag is cleared whenever the counter simply advanced by one from the previous packet.

Alongside the trace store, a separate 64-entry event FIFO keeps only the unusual moments: exceptions and branches whose taken/not-taken outcome differs from the last outcome seen for that branch. Branch history lives in a small table indexed by the low bits of the program counter. The event FIFO never overwrites. When it is full, new events are dropped and a sticky overflow flag tells the host that something was lost.

A host reads either store through a pop strobe. Data appears one cycle later, and each store has its own empty flag.

Top module: `trace_event_logger`

## Requirements
- R1: After reset both stores are empty, `ring_wrapped` and `evt_overflow` are 0, and both read data outputs are 0.
- R2: A trace packet is `{pc_flag, pc, tos, op}`, with `pc_flag` at the MSB, then PC_W bits of pc, then TOS_W bits of tos, then OP_W bits of op in the low bits. `pc_flag` is 0 and the pc field is all zeros when the pc equals the previous packet's pc plus one. Otherwise, and always for the first packet after reset, `pc_flag` is 1 and the pc field holds the pc.
- R3: Each cycle with `tr_valid` high writes exactly one packet to the trace store. Cycles with `tr_valid` low write nothing.
- R4: A packet written while the trace store holds RING_DEPTH entries, with no pop in that cycle, replaces the oldest entry and sets `ring_wrapped`. Later reads return the newest RING_DEPTH packets, oldest first.
- R5: A pop on a non-empty store presents the oldest entry on its read data output in the cycle after the pop. A pop on an empty store is ignored, the store stays empty, and the read data output holds its value.
- R6: A branch (`br_valid` with `tr_valid`) is looked up in a table indexed by `tr_pc[IDX_W-1:0]`. The first outcome seen for an index is recorded silently. A later outcome that differs from the recorded one logs a branch event. Every branch updates the recorded outcome.
- R7: An exception (`exc_valid` with `tr_valid`) always logs an event carrying `exc_code`. If a branch change happens in the same cycle, only the exception is logged, and the table is still updated.
- R8: An event entry is `{kind, taken, pc, code}`: kind at the MSB (1 = exception, 0 = branch), then the branch outcome (0 for exceptions), then PC_W bits of pc, then EXC_W bits of code (0 for branches).
- R9: The event FIFO holds EVT_DEPTH (64) entries. An event arriving while it is full, with no pop in that cycle, is dropped, the stored entries are kept, and `evt_overflow` is set.
- R10: `ring_wrapped` and `evt_overflow` stay set until `ovf_clr` is pulsed. If a new overwrite or drop coincides with `ovf_clr`, the flag remains set.
- R11: `br_valid` and `exc_valid` have no effect in cycles where `tr_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tr_valid | input | 1 | Core executed an instruction this cycle |
| tr_pc | input | PC_W | Program counter of the executed instruction |
| tr_tos | input | TOS_W | Top-of-stack value |
| tr_op | input | OP_W | Opcode |
| br_valid | input | 1 | The instruction is a resolved branch |
| br_taken | input | 1 | Branch outcome, 1 = taken |
| exc_valid | input | 1 | The instruction raised an exception |
| exc_code | input | EXC_W | Exception cause code |
| ring_pop | input | 1 | Host pop strobe for the trace store |
| evt_pop | input | 1 | Host pop strobe for the event FIFO |
| ovf_clr | input | 1 | Clears the wrap and overflow flags |
| ring_rd_data | output | 1+PC_W+TOS_W+OP_W | Popped trace packet |
| ring_empty | output | 1 | Trace store is empty |
| ring_wrapped | output | 1 | Sticky: a packet replaced an unread one |
| evt_rd_data | output | 2+PC_W+EXC_W | Popped event entry |
| evt_empty | output | 1 | Event FIFO is empty |
| evt_overflow | output | 1 | Sticky: an event was dropped |

## Verification
The empty flags and the two sticky flags change at the first rising edge after the stimulus cycle. Popped data is due at the rising edge after the pop strobe, so every result is visible one cycle after its cause. The bench changes inputs on the falling edge. It compares status and data at the following falling edge, which is half a cycle after the edge that registers the result. The scoreboard queues the expected entry while the pop is issued and compares it one cycle later.

// File: rtl/trl_pkg.sv
package trl_pkg;
  typedef enum logic {EV_BRANCH = 1'b0, EV_EXCEPT = 1'b1} ev_kind_e;

  // Next index in a circular buffer of the given depth.
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/trl_queue.sv
module trl_queue #(
  parameter int W         = 8,
  parameter int DEPTH     = 16,
  parameter bit OVERWRITE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  input  logic         clr,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         flag,
  output logic         lost
);
  import trl_pkg::*;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full, pop_ok, wr_ok, adv_old;

  assign full   = (cnt == CW'(DEPTH));
  assign pop_ok = pop && (cnt != '0);
  assign empty  = (cnt == '0);
  assign lost   = push && full && !pop_ok;

  generate
    if (OVERWRITE) begin : g_ovw
      assign wr_ok   = push;
      assign adv_old = lost;
    end else begin : g_drop
      assign wr_ok   = push && !lost;
      assign adv_old = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      dout <= '0;
      flag <= 1'b0;
    end else begin
      if (pop_ok) dout <= mem[rp];
      if (wr_ok) wp <= AW'(wrap_inc(32'(wp), DEPTH));
      if (pop_ok || adv_old) rp <= AW'(wrap_inc(32'(rp), DEPTH));
      case ({wr_ok, pop_ok})
        2'b10:   if (!full) cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
      if (lost) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/trl_trace_pack.sv
module trl_trace_pack #(
  parameter int PC_W  = 16,
  parameter int TOS_W = 16,
  parameter int OP_W  = 8,
  localparam int PKT_W = 1 + PC_W + TOS_W + OP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [PC_W-1:0]  pc,
  input  logic [TOS_W-1:0] tos,
  input  logic [OP_W-1:0]  op,
  output logic [PKT_W-1:0] pkt
);
  logic [PC_W-1:0] last_pc;
  logic            have_last;
  logic            seq;

  function automatic logic follows(input logic [PC_W-1:0] prev, input logic [PC_W-1:0] cur);
    return cur == (prev + PC_W'(1));
  endfunction

  assign seq = have_last && follows(last_pc, pc);
  assign pkt = {!seq, (seq ? {PC_W{1'b0}} : pc), tos, op};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_pc   <= '0;
      have_last <= 1'b0;
    end else if (valid) begin
      last_pc   <= pc;
      have_last <= 1'b1;
    end
  end
endmodule

// File: rtl/trl_branch_tracker.sv
module trl_branch_tracker #(
  parameter int IDX_W = 4,
  localparam int N = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [IDX_W-1:0] idx,
  input  logic             taken,
  output logic             change
);
  logic [N-1:0] seen;
  logic [N-1:0] dir;

  assign change = valid && seen[idx] && (dir[idx] != taken);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= '0;
      dir  <= '0;
    end else if (valid) begin
      seen[idx] <= 1'b1;
      dir[idx]  <= taken;
    end
  end
endmodule

// File: rtl/trace_event_logger.sv
module trace_event_logger #(
  parameter int PC_W       = 16,
  parameter int TOS_W      = 16,
  parameter int OP_W       = 8,
  parameter int EXC_W      = 4,
  parameter int RING_DEPTH = 16,
  parameter int EVT_DEPTH  = 64,
  parameter int IDX_W      = 4,
  localparam int RING_W = 1 + PC_W + TOS_W + OP_W,
  localparam int EVT_W  = 2 + PC_W + EXC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tr_valid,
  input  logic [PC_W-1:0]   tr_pc,
  input  logic [TOS_W-1:0]  tr_tos,
  input  logic [OP_W-1:0]   tr_op,
  input  logic              br_valid,
  input  logic              br_taken,
  input  logic              exc_valid,
  input  logic [EXC_W-1:0]  exc_code,
  input  logic              ring_pop,
  input  logic              evt_pop,
  input  logic              ovf_clr,
  output logic [RING_W-1:0] ring_rd_data,
  output logic              ring_empty,
  output logic              ring_wrapped,
  output logic [EVT_W-1:0]  evt_rd_data,
  output logic              evt_empty,
  output logic              evt_overflow
);
  import trl_pkg::*;

  logic [RING_W-1:0] pkt;
  logic [EVT_W-1:0]  evt_word;
  logic              br_change, evt_push, ring_lost, evt_lost;
  ev_kind_e          kind;

  trl_trace_pack #(.PC_W(PC_W), .TOS_W(TOS_W), .OP_W(OP_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .valid(tr_valid),
    .pc(tr_pc), .tos(tr_tos), .op(tr_op), .pkt(pkt)
  );

  trl_branch_tracker #(.IDX_W(IDX_W)) u_btrk (
    .clk(clk), .rst_n(rst_n), .valid(tr_valid && br_valid),
    .idx(tr_pc[IDX_W-1:0]), .taken(br_taken), .change(br_change)
  );

  assign kind     = exc_valid ? EV_EXCEPT : EV_BRANCH;
  assign evt_push = tr_valid && (exc_valid || br_change);
  assign evt_word = exc_valid ? {kind, 1'b0, tr_pc, exc_code}
                              : {kind, br_taken, tr_pc, {EXC_W{1'b0}}};

  trl_queue #(.W(RING_W), .DEPTH(RING_DEPTH), .OVERWRITE(1'b1)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(tr_valid), .din(pkt), .pop(ring_pop),
    .clr(ovf_clr), .dout(ring_rd_data), .empty(ring_empty),
    .flag(ring_wrapped), .lost(ring_lost)
  );

  trl_queue #(.W(EVT_W), .DEPTH(EVT_DEPTH), .OVERWRITE(1'b0)) u_evt (
    .clk(clk), .rst_n(rst_n), .push(evt_push), .din(evt_word), .pop(evt_pop),
    .clr(ovf_clr), .dout(evt_rd_data), .empty(evt_empty),
    .flag(evt_overflow), .lost(evt_lost)
  );
endmodule

// File: rtl/trace_event_logger_chk.sv
module trace_event_logger_chk (
  input logic clk,
  input logic rst_n,
  input logic tr_valid,
  input logic ovf_clr,
  input logic ring_empty,
  input logic ring_wrapped,
  input logic evt_empty,
  input logic evt_overflow,
  input logic ring_lost,
  input logic evt_lost,
  input logic evt_push
);
  p_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tr_valid |=> !ring_empty);

  p_wrap_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ring_lost |=> ring_wrapped);

  p_idle_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_empty && !tr_valid) |=> ring_empty);

  p_evt_stored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_push |=> !evt_empty);

  p_drop_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_lost |=> evt_overflow);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_overflow && !ovf_clr) |=> evt_overflow);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !evt_lost) |=> !evt_overflow);

  p_wrap_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !ring_lost) |=> !ring_wrapped);
endmodule

bind trace_event_logger trace_event_logger_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tr_valid(tr_valid), .ovf_clr(ovf_clr),
  .ring_empty(ring_empty), .ring_wrapped(ring_wrapped),
  .evt_empty(evt_empty), .evt_overflow(evt_overflow),
  .ring_lost(ring_lost), .evt_lost(evt_lost), .evt_push(evt_push)
);

// File: tb/trace_event_logger_bench.sv
module trace_event_logger_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 16, TOS_W = 16, OP_W = 8, EXC_W = 4;
  localparam int RING_DEPTH = 16, EVT_DEPTH = 64, IDX_W = 4;
  localparam int RING_W = 1 + PC_W + TOS_W + OP_W;
  localparam int EVT_W  = 2 + PC_W + EXC_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tr_valid = 0, br_valid = 0, br_taken = 0, exc_valid = 0;
  logic ring_pop = 0, evt_pop = 0, ovf_clr = 0;
  logic [PC_W-1:0] tr_pc = '0;
  logic [TOS_W-1:0] tr_tos = '0;
  logic [OP_W-1:0] tr_op = '0;
  logic [EXC_W-1:0] exc_code = '0;
  logic [RING_W-1:0] ring_rd_data;
  logic [EVT_W-1:0] evt_rd_data;
  logic ring_empty, ring_wrapped, evt_empty, evt_overflow;

  trace_event_logger #(.PC_W(PC_W), .TOS_W(TOS_W), .OP_W(OP_W), .EXC_W(EXC_W),
    .RING_DEPTH(RING_DEPTH), .EVT_DEPTH(EVT_DEPTH), .IDX_W(IDX_W)) u_trace_event_logger (
    .clk(clk), .rst_n(rst_n), .tr_valid(tr_valid), .tr_pc(tr_pc), .tr_tos(tr_tos),
    .tr_op(tr_op), .br_valid(br_valid), .br_taken(br_taken), .exc_valid(exc_valid),
    .exc_code(exc_code), .ring_pop(ring_pop), .evt_pop(evt_pop), .ovf_clr(ovf_clr),
    .ring_rd_data(ring_rd_data), .ring_empty(ring_empty), .ring_wrapped(ring_wrapped),
    .evt_rd_data(evt_rd_data), .evt_empty(evt_empty), .evt_overflow(evt_overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [RING_W-1:0] mring[$], ring_exp[$];
  logic [EVT_W-1:0]  mevt[$], evt_exp[$];
  bit have_pc = 0;
  logic [PC_W-1:0] prev_pc = '0;
  bit bseen[16], bdir[16];
  bit exp_wrap = 0, exp_ovf = 0;
  bit ring_pop_exp = 0, evt_pop_exp = 0, ring_due = 0, evt_due = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: applies one core cycle and updates the expected model.
  task automatic drive(input logic [PC_W-1:0] pc, input logic [TOS_W-1:0] tos,
                       input logic [OP_W-1:0] op, input bit tv, input bit bv,
                       input bit tk, input bit ev, input logic [EXC_W-1:0] code,
                       input bit clr);
    logic [RING_W-1:0] pkt;
    logic [EVT_W-1:0]  e;
    bit seq, chg, lost_r, lost_e, epush;
    int ix;
    @(negedge clk);
    tr_valid = tv; tr_pc = pc; tr_tos = tos; tr_op = op;
    br_valid = bv; br_taken = tk; exc_valid = ev; exc_code = code; ovf_clr = clr;
    ring_pop = 0; evt_pop = 0; ring_pop_exp = 0; evt_pop_exp = 0;
    lost_r = 0; lost_e = 0; epush = 0; e = '0;
    if (tv) begin
      seq = have_pc && (pc == prev_pc + PC_W'(1));
      pkt = {!seq, (seq ? {PC_W{1'b0}} : pc), tos, op};
      if (mring.size() == RING_DEPTH) begin void'(mring.pop_front()); lost_r = 1; end
      mring.push_back(pkt);
      have_pc = 1; prev_pc = pc;
      ix = int'(pc[3:0]);
      chg = bv && bseen[ix] && (bdir[ix] != tk);
      if (bv) begin bseen[ix] = 1; bdir[ix] = tk; end
      if (ev) begin e = {1'b1, 1'b0, pc, code}; epush = 1; end
      else if (chg) begin e = {1'b0, tk, pc, {EXC_W{1'b0}}}; epush = 1; end
      if (epush) begin
        if (mevt.size() == EVT_DEPTH) lost_e = 1;
        else mevt.push_back(e);
      end
    end
    exp_wrap = lost_r ? 1'b1 : (clr ? 1'b0 : exp_wrap);
    exp_ovf  = lost_e ? 1'b1 : (clr ? 1'b0 : exp_ovf);
  endtask

  task automatic idle();
    drive('0, '0, '0, 0, 0, 0, 0, '0, 0);
  endtask

  task automatic pop_ring();
    @(negedge clk);
    tr_valid = 0; br_valid = 0; exc_valid = 0; ovf_clr = 0;
    evt_pop = 0; evt_pop_exp = 0; ring_pop = 1;
    if (mring.size() > 0) begin ring_exp.push_back(mring.pop_front()); ring_pop_exp = 1; end
    else ring_pop_exp = 0;
  endtask

  task automatic pop_evt();
    @(negedge clk);
    tr_valid = 0; br_valid = 0; exc_valid = 0; ovf_clr = 0;
    ring_pop = 0; ring_pop_exp = 0; evt_pop = 1;
    if (mevt.size() > 0) begin evt_exp.push_back(mevt.pop_front()); evt_pop_exp = 1; end
    else evt_pop_exp = 0;
  endtask

  task automatic chk_flags(input string req);
    check({req, " ring_empty"}, 64'(ring_empty), 64'(mring.size() == 0));
    check({req, " evt_empty"}, 64'(evt_empty), 64'(mevt.size() == 0));
    check({req, " ring_wrapped"}, 64'(ring_wrapped), 64'(exp_wrap));
    check({req, " evt_overflow"}, 64'(evt_overflow), 64'(exp_ovf));
  endtask

  // Monitor: read data is due one cycle after the pop.
  always @(posedge clk) begin
    ring_due <= ring_pop_exp;
    evt_due  <= evt_pop_exp;
  end

  always @(negedge clk) begin
    if (ring_due) check("R2 R4 R5 ring packet", 64'(ring_rd_data), 64'(ring_exp.pop_front()));
    if (evt_due)  check("R6 R7 R8 R9 event entry", 64'(evt_rd_data), 64'(evt_exp.pop_front()));
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL all requirements: watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [RING_W-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 ring_empty", 64'(ring_empty), 64'd1);
    check("R1 evt_empty", 64'(evt_empty), 64'd1);
    check("R1 ring_wrapped", 64'(ring_wrapped), 64'd0);
    check("R1 evt_overflow", 64'(evt_overflow), 64'd0);
    check("R1 ring_rd_data", 64'(ring_rd_data), 64'd0);
    check("R1 evt_rd_data", 64'(evt_rd_data), 64'd0);

    // R11: side inputs without tr_valid change nothing; R3 no write either
    drive(16'h55, 16'h1, 8'h2, 0, 1, 1, 1, 4'h3, 0);
    idle();
    check("R11 evt_empty", 64'(evt_empty), 64'd1);
    check("R3 ring_empty", 64'(ring_empty), 64'd1);

    // R2 compression pattern
    drive(16'd100, 16'hAAAA, 8'h11, 1, 0, 0, 0, '0, 0);
    drive(16'd101, 16'hBBBB, 8'h12, 1, 0, 0, 0, '0, 0);
    drive(16'd102, 16'hCCCC, 8'h13, 1, 0, 0, 0, '0, 0);
    drive(16'd200, 16'hDDDD, 8'h14, 1, 0, 0, 0, '0, 0);
    drive(16'd201, 16'hEEEE, 8'h15, 1, 0, 0, 0, '0, 0);
    idle();
    chk_flags("R3");
    for (int i = 0; i < 5; i++) pop_ring();
    idle(); idle();
    chk_flags("R5");

    // R5 pop on empty store
    held = ring_rd_data;
    pop_ring();
    idle();
    check("R5 empty pop holds data", 64'(ring_rd_data), 64'(held));
    check("R5 empty stays", 64'(ring_empty), 64'd1);

    // R6 R7 branch changes and exception priority (IDX_W = 4)
    drive(16'h13, 16'h1, 8'h20, 1, 1, 1, 0, '0, 0);
    drive(16'h13, 16'h2, 8'h20, 1, 1, 1, 0, '0, 0);
    drive(16'h13, 16'h3, 8'h20, 1, 1, 0, 0, '0, 0);
    drive(16'h15, 16'h4, 8'h21, 1, 1, 0, 0, '0, 0);
    drive(16'h15, 16'h5, 8'h21, 1, 1, 1, 0, '0, 0);
    drive(16'h20, 16'h6, 8'h22, 1, 1, 1, 0, '0, 0);
    drive(16'h30, 16'h7, 8'h23, 1, 1, 0, 1, 4'h5, 0);
    drive(16'h40, 16'h8, 8'h24, 1, 1, 0, 0, '0, 0);
    idle();
    check("R7 expected event count", 64'(mevt.size()), 64'd3);
    chk_flags("R6");
    for (int i = 0; i < 3; i++) pop_evt();
    idle(); idle();
    check("R6 R7 only three events", 64'(evt_empty), 64'd1);

    // R4 overwrite of oldest packets
    for (int i = 0; i < 20; i++)
      drive(16'(16'h400 + ((i % 3 == 0) ? i * 2 : i)), 16'(i), 8'(i + 8'h40), 1, 0, 0, 0, '0, 0);
    idle();
    chk_flags("R4");
    for (int i = 0; i < RING_DEPTH; i++) pop_ring();
    idle(); idle();
    chk_flags("R4");
    drive('0, '0, '0, 0, 0, 0, 0, '0, 1);
    idle();
    chk_flags("R10");

    // R9 event FIFO full and drop
    for (int i = 0; i < EVT_DEPTH + 2; i++)
      drive(16'(16'h800 + i * 4), 16'(i), 8'h66, 1, 0, 0, 1, 4'(i), 0);
    idle();
    chk_flags("R9");
    for (int i = 0; i < EVT_DEPTH; i++) pop_evt();
    idle(); idle();
    chk_flags("R9");
    drive('0, '0, '0, 0, 0, 0, 0, '0, 1);
    idle();
    chk_flags("R10");

    // R10 set wins over clear in the same cycle
    for (int i = 0; i < EVT_DEPTH; i++)
      drive(16'(16'h2000 + i * 4), 16'(i), 8'h77, 1, 0, 0, 1, 4'(i), 0);
    drive(16'h3000, 16'h1, 8'h78, 1, 0, 0, 1, 4'h9, 1);
    idle();
    check("R10 set wins", 64'(evt_overflow), 64'd1);
    chk_flags("R10");
    drive('0, '0, '0, 0, 0, 0, 0, '0, 1);
    idle();
    check("R10 cleared", 64'(evt_overflow), 64'd0);
    chk_flags("R10");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule